// File: doc/BRIEF.md
# Microcontroller GPIO Port Register

This block is one eight-pin general-purpose I/O port attached to a byte-wide special-function-register bus of an 8051-style CPU. It keeps three byte registers: an output latch, an input-mode register that marks each pin as digital or analog, and an output-mode register that marks each pin as push-pull or open-drain. From these it derives a per-pin output-enable and output-value pair for the pad cells. The latch takes both whole-byte writes and single-bit writes.

Reads at the latch address return the pin levels by default. Pin inputs pass through a two-flop synchronizer first, and analog pins read as zero. When the CPU marks the read as part of a read-modify-write instruction, the same address returns the latch contents instead. The read path is combinational from the bus address, so data is valid in the cycle the address is presented. Register writes take effect on the clock edge at which the strobe is sampled.

Top module: `sfr_gpio_port`

## Requirements
- R1: After synchronous reset the latch reads 0xFF, the input-mode register reads 0xFF (all pins digital), the output-mode register reads 0x00 (all open-drain), and pad_oe and pad_out are 0x00.
- R2: A byte write with wr_en high loads the register decoded from bus_addr (latch 0x80, input mode 0xF1, output mode 0xA4) at the next clock edge. A write to any other address changes no register.
- R3: A bit write (bit_wr_en high) sets latch bit bit_sel to bit_val and leaves the other seven latch bits unchanged.
- R4: If a byte write to the latch address and a bit write arrive in the same cycle, the byte write wins and the bit write is discarded.
- R5: A normal read (rd_rmw low) at the latch address returns the pin levels. A change on pin_in first shows in rd_data after the second rising clock edge that follows it.
- R6: A read at the latch address with rd_rmw high returns the latch contents, whatever the pin levels.
- R7: In a normal read, a pin whose input-mode bit is 0 (analog) reads as 0.
- R8: On a digital pin (input-mode bit 1), pad_oe is 1 when the latch bit is 0 or the output-mode bit is 1 (push-pull). pad_out equals the latch bit when pad_oe is 1 and is 0 otherwise.
- R9: On an analog pin, pad_oe and pad_out are 0 whatever the latch and output-mode bits are.
- R10: Reads at the input-mode and output-mode addresses return those registers. A read at any unmapped address returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 8 | Register address for reads and byte writes |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte write data |
| bit_wr_en | input | 1 | Single-bit latch write strobe |
| bit_sel | input | 3 | Latch bit index for bit writes |
| bit_val | input | 1 | Value for the bit write |
| rd_rmw | input | 1 | Read belongs to a read-modify-write instruction |
| rd_data | output | 8 | Read data |
| pin_in | input | 8 | Pin levels from the pads (asynchronous) |
| pad_oe | output | 8 | Per-pin driver enable |
| pad_out | output | 8 | Per-pin driven value |

## Verification
On every cycle the assertions check the pad rules: analog pins never drive, and pad_out stays low whenever its enable is low. They also check that read-modify-write reads mirror the latch, that normal reads track pin_in delayed by two edges and masked by the input mode, and that byte and bit writes reach the latch with the right priority. Only the bench scenarios show the reset values, the exact edge at which a pin change appears, that unmapped writes leave every register alone, and full agreement with a reference model under random mixes of writes, pin changes and mode settings.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int PORT_W = 8;
    localparam int SEL_W  = $clog2(PORT_W);

    typedef logic [PORT_W-1:0] port_vec_t;

    // Which register a bus address selects
    typedef enum logic [1:0] {
        SEL_NONE,
        SEL_LATCH,
        SEL_INMODE,
        SEL_OUTMODE
    } reg_sel_e;

    typedef struct packed {
        port_vec_t latch;    // output data
        port_vec_t inmode;   // 1 = digital, 0 = analog
        port_vec_t outmode;  // 1 = push-pull, 0 = open-drain
    } port_regs_t;

    typedef struct packed {
        logic oe;
        logic val;
    } pad_drive_t;

    localparam port_vec_t LATCH_RST   = '1;
    localparam port_vec_t INMODE_RST  = '1;
    localparam port_vec_t OUTMODE_RST = '0;

    function automatic reg_sel_e decode_addr(
        input logic [7:0] addr,
        input logic [7:0] a_latch,
        input logic [7:0] a_inmode,
        input logic [7:0] a_outmode
    );
        if (addr == a_latch)        return SEL_LATCH;
        else if (addr == a_inmode)  return SEL_INMODE;
        else if (addr == a_outmode) return SEL_OUTMODE;
        else                        return SEL_NONE;
    endfunction

    // Drive decision for one pin
    function automatic pad_drive_t pin_drive(
        input logic latch_b,
        input logic digital_b,
        input logic push_pull_b
    );
        pad_drive_t d;
        d.oe  = digital_b & (push_pull_b | ~latch_b);
        d.val = d.oe & latch_b;
        return d;
    endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) stg[0] <= '0;
        else     stg[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[s] <= '0;
            else     stg[s] <= stg[s-1];
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  reg_sel_e            sel,
    input  logic                wr_en,
    input  port_vec_t           wr_data,
    input  logic                bit_wr_en,
    input  logic [SEL_W-1:0]    bit_sel,
    input  logic                bit_val,
    output port_regs_t          regs
);
    logic byte_to_latch;
    assign byte_to_latch = wr_en && (sel == SEL_LATCH);

    always_ff @(posedge clk) begin
        if (rst) begin
            regs.latch   <= LATCH_RST;
            regs.inmode  <= INMODE_RST;
            regs.outmode <= OUTMODE_RST;
        end else begin
            if (wr_en) begin
                case (sel)
                    SEL_LATCH:   regs.latch   <= wr_data;
                    SEL_INMODE:  regs.inmode  <= wr_data;
                    SEL_OUTMODE: regs.outmode <= wr_data;
                    default:     ;
                endcase
            end
            // Bit write yields to a simultaneous byte write on the latch
            if (bit_wr_en && !byte_to_latch)
                regs.latch[bit_sel] <= bit_val;
        end
    end
endmodule

// File: rtl/gpio_pad_ctl.sv
module gpio_pad_ctl
    import gpio_port_pkg::*;
(
    input  port_regs_t regs,
    output port_vec_t  pad_oe,
    output port_vec_t  pad_out
);
    for (genvar p = 0; p < PORT_W; p++) begin : g_pin
        pad_drive_t drv;
        assign drv        = pin_drive(regs.latch[p], regs.inmode[p], regs.outmode[p]);
        assign pad_oe[p]  = drv.oe;
        assign pad_out[p] = drv.val;
    end
endmodule

// File: rtl/gpio_rd_mux.sv
module gpio_rd_mux
    import gpio_port_pkg::*;
(
    input  reg_sel_e   sel,
    input  logic       rmw,
    input  port_regs_t regs,
    input  port_vec_t  pins_sync,
    output port_vec_t  rd_data
);
    always_comb begin
        unique case (sel)
            SEL_LATCH:   rd_data = rmw ? regs.latch : (pins_sync & regs.inmode);
            SEL_INMODE:  rd_data = regs.inmode;
            SEL_OUTMODE: rd_data = regs.outmode;
            default:     rd_data = '0;
        endcase
    end
endmodule

// File: rtl/sfr_gpio_port.sv
module sfr_gpio_port
    import gpio_port_pkg::*;
#(
    parameter logic [7:0] LATCH_ADDR   = 8'h80,
    parameter logic [7:0] INMODE_ADDR  = 8'hF1,
    parameter logic [7:0] OUTMODE_ADDR = 8'hA4,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [7:0]       bus_addr,
    input  logic             wr_en,
    input  logic [PORT_W-1:0] wr_data,
    input  logic             bit_wr_en,
    input  logic [SEL_W-1:0] bit_sel,
    input  logic             bit_val,
    input  logic             rd_rmw,
    output logic [PORT_W-1:0] rd_data,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pad_oe,
    output logic [PORT_W-1:0] pad_out
);
    reg_sel_e   sel;
    port_regs_t regs_q;
    port_vec_t  pins_sync;

    assign sel = decode_addr(bus_addr, LATCH_ADDR, INMODE_ADDR, OUTMODE_ADDR);

    gpio_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .sel       (sel),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .bit_wr_en (bit_wr_en),
        .bit_sel   (bit_sel),
        .bit_val   (bit_val),
        .regs      (regs_q)
    );

    gpio_in_sync #(.WIDTH(PORT_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (pins_sync)
    );

    gpio_pad_ctl u_pad (
        .regs    (regs_q),
        .pad_oe  (pad_oe),
        .pad_out (pad_out)
    );

    gpio_rd_mux u_rd (
        .sel       (sel),
        .rmw       (rd_rmw),
        .regs      (regs_q),
        .pins_sync (pins_sync),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/gpio_port_checker.sv
module gpio_port_checker #(
    parameter logic [7:0] LATCH_ADDR = 8'h80
) (
    input logic       clk,
    input logic       rst,
    input logic [7:0] bus_addr,
    input logic       wr_en,
    input logic [7:0] wr_data,
    input logic       bit_wr_en,
    input logic [2:0] bit_sel,
    input logic       bit_val,
    input logic       rd_rmw,
    input logic [7:0] rd_data,
    input logic [7:0] pin_in,
    input logic [7:0] pad_oe,
    input logic [7:0] pad_out,
    input logic [7:0] latch_q,
    input logic [7:0] inmode_q
);
    logic [1:0] since_rst;
    logic [7:0] bmask;
    logic       byte_latch;

    assign bmask      = 8'd1 << bit_sel;
    assign byte_latch = wr_en && (bus_addr == LATCH_ADDR);

    always_ff @(posedge clk) begin
        if (rst)                  since_rst <= '0;
        else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
    end

    // R1: out of reset every pin is open-drain with latch high, so no driver is on
    assert_reset_pads_R1: assert property (@(posedge clk)
        rst |=> (pad_oe == 8'h00 && pad_out == 8'h00));

    // R3: a bit write changes only its selected bit
    assert_bit_write_R3: assert property (@(posedge clk) disable iff (rst)
        (bit_wr_en && !byte_latch) |=>
            (((latch_q & ~$past(bmask)) == ($past(latch_q) & ~$past(bmask))) &&
             (latch_q[$past(bit_sel)] == $past(bit_val))));

    // R4: a byte write to the latch wins over any bit write
    assert_byte_wins_R4: assert property (@(posedge clk) disable iff (rst)
        byte_latch |=> (latch_q == $past(wr_data)));

    // R5 / R7: normal reads track pins two edges late, analog bits zero
    assert_pin_read_R5: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && bus_addr == LATCH_ADDR && !rd_rmw) |->
            (rd_data == ($past(pin_in, 2) & inmode_q)));

    // R6: read-modify-write reads mirror the latch
    assert_rmw_read_R6: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == LATCH_ADDR && rd_rmw) |-> (rd_data == latch_q));

    // R8: no value is presented without the enable
    assert_out_gated_R8: assert property (@(posedge clk) disable iff (rst)
        ((pad_out & ~pad_oe) == 8'h00));

    // R9: analog pins never drive
    assert_analog_off_R9: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & ~inmode_q) == 8'h00));
endmodule

bind sfr_gpio_port gpio_port_checker #(.LATCH_ADDR(LATCH_ADDR)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .bit_wr_en (bit_wr_en),
    .bit_sel   (bit_sel),
    .bit_val   (bit_val),
    .rd_rmw    (rd_rmw),
    .rd_data   (rd_data),
    .pin_in    (pin_in),
    .pad_oe    (pad_oe),
    .pad_out   (pad_out),
    .latch_q   (regs_q.latch),
    .inmode_q  (regs_q.inmode)
);

// File: tb/test_sfr_gpio_port.sv
module test_sfr_gpio_port;
    localparam logic [7:0] A_LATCH = 8'h80;
    localparam logic [7:0] A_INM   = 8'hF1;
    localparam logic [7:0] A_OUTM  = 8'hA4;
    localparam logic [7:0] A_NONE  = 8'h55;

    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] bus_addr;
    logic       wr_en;
    logic [7:0] wr_data;
    logic       bit_wr_en;
    logic [2:0] bit_sel;
    logic       bit_val;
    logic       rd_rmw;
    logic [7:0] rd_data;
    logic [7:0] pin_in;
    logic [7:0] pad_oe;
    logic [7:0] pad_out;

    int nchk  = 0;
    int nfail = 0;
    bit done  = 0;

    logic [7:0] m_lat, m_inm, m_outm, m_pin;

    sfr_gpio_port i_sfr_gpio_port (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .wr_en(wr_en), .wr_data(wr_data),
        .bit_wr_en(bit_wr_en), .bit_sel(bit_sel), .bit_val(bit_val), .rd_rmw(rd_rmw),
        .rd_data(rd_data), .pin_in(pin_in), .pad_oe(pad_oe), .pad_out(pad_out)
    );

    always #10 clk = ~clk;   // 50 MHz

    function automatic logic [7:0] exp_oe(input logic [7:0] l, im, om);
        return im & (om | ~l);
    endfunction

    function automatic logic [7:0] exp_out(input logic [7:0] l, im, om);
        return exp_oe(l, im, om) & l;
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        wr_en = 0; bit_wr_en = 0;
    endtask

    task automatic rd(input logic [7:0] a, input logic rmw, output logic [7:0] d);
        bus_addr = a; rd_rmw = rmw;
        #1 d = rd_data;
    endtask

    // Compare every readable view and pad output against the model
    task automatic check_all(input string ctx);
        logic [7:0] d;
        rd(A_LATCH, 1'b0, d); chk({"R5/R7 pin read ", ctx}, d, m_pin & m_inm);
        rd(A_LATCH, 1'b1, d); chk({"R6 rmw read ", ctx}, d, m_lat);
        rd(A_INM,   1'b0, d); chk({"R10 inmode read ", ctx}, d, m_inm);
        rd(A_OUTM,  1'b0, d); chk({"R10 outmode read ", ctx}, d, m_outm);
        rd(A_NONE,  1'b0, d); chk({"R10 unmapped read ", ctx}, d, 8'h00);
        chk({"R8/R9 pad_oe ", ctx}, pad_oe, exp_oe(m_lat, m_inm, m_outm));
        chk({"R8/R9 pad_out ", ctx}, pad_out, exp_out(m_lat, m_inm, m_outm));
    endtask

    task automatic byte_wr(input logic [7:0] a, input logic [7:0] d);
        bus_addr = a; wr_data = d; wr_en = 1;
        step();
        if (a == A_LATCH)     m_lat  = d;
        else if (a == A_INM)  m_inm  = d;
        else if (a == A_OUTM) m_outm = d;
    endtask

    task automatic bit_wr(input logic [2:0] s, input logic v);
        bit_sel = s; bit_val = v; bit_wr_en = 1;
        step();
        m_lat[s] = v;
    endtask

    task automatic set_pins(input logic [7:0] p);
        pin_in = p;
        step(); step();
        m_pin = p;
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            nchk++; nfail++;
            $display("FAIL watchdog expired, no requirement completed");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'd20240611));
        rst = 1; bus_addr = A_NONE; wr_en = 0; wr_data = 0; bit_wr_en = 0;
        bit_sel = 0; bit_val = 0; rd_rmw = 0; pin_in = 8'h00;
        @(negedge clk); step(); step();
        rst = 0;
        m_lat = 8'hFF; m_inm = 8'hFF; m_outm = 8'h00; m_pin = 8'h00;

        // R1: reset values
        rd(A_LATCH, 1'b1, d); chk("R1 latch reset", d, 8'hFF);
        rd(A_INM, 1'b0, d);   chk("R1 inmode reset", d, 8'hFF);
        rd(A_OUTM, 1'b0, d);  chk("R1 outmode reset", d, 8'h00);
        chk("R1 pad_oe reset", pad_oe, 8'h00);
        chk("R1 pad_out reset", pad_out, 8'h00);

        // R5: synchronizer latency, exact edge
        pin_in = 8'hA5;
        rd(A_LATCH, 1'b0, d); chk("R5 before edge", d, 8'h00);
        step();
        rd(A_LATCH, 1'b0, d); chk("R5 after one edge", d, 8'h00);
        step();
        rd(A_LATCH, 1'b0, d); chk("R5 after two edges", d, 8'hA5);
        m_pin = 8'hA5;

        // R6: rmw read ignores pins
        rd(A_LATCH, 1'b1, d); chk("R6 rmw returns latch", d, 8'hFF);

        // R7 and R9: analog upper nibble
        byte_wr(A_INM, 8'h0F);
        rd(A_LATCH, 1'b0, d); chk("R7 analog reads zero", d, 8'h05);
        byte_wr(A_OUTM, 8'hFF);
        byte_wr(A_LATCH, 8'h3C);
        chk("R9 analog pins off, R8 push-pull on", pad_oe, 8'h0F);
        chk("R8 pad_out value", pad_out, 8'h0C);

        // R8 open-drain: latch 1 releases, latch 0 drives
        byte_wr(A_INM, 8'hFF);
        byte_wr(A_OUTM, 8'h00);
        chk("R8 open-drain oe", pad_oe, 8'hC3);
        chk("R8 open-drain out", pad_out, 8'h00);

        // R3: single-bit write
        bit_wr(3'd1, 1'b1);
        rd(A_LATCH, 1'b1, d); chk("R3 bit set", d, 8'h3E);
        bit_wr(3'd5, 1'b0);
        rd(A_LATCH, 1'b1, d); chk("R3 bit clear", d, 8'h1E);

        // R4: byte write beats bit write
        bus_addr = A_LATCH; wr_data = 8'h00; wr_en = 1;
        bit_sel = 3'd0; bit_val = 1'b1; bit_wr_en = 1;
        step();
        m_lat = 8'h00;
        rd(A_LATCH, 1'b1, d); chk("R4 byte write wins", d, 8'h00);

        // R2: unmapped write touches nothing
        byte_wr(A_NONE, 8'hAA);
        check_all("R2 after unmapped write");

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op = $urandom % 5;
            case (op)
                0: begin
                    int k = $urandom % 4;
                    logic [7:0] a = (k == 0) ? A_LATCH : (k == 1) ? A_INM :
                                    (k == 2) ? A_OUTM : A_NONE;
                    byte_wr(a, 8'($urandom));
                end
                1: bit_wr(3'($urandom), 1'($urandom));
                2: begin
                    logic [7:0] dv = 8'($urandom);
                    bus_addr = A_LATCH; wr_data = dv; wr_en = 1;
                    bit_sel = 3'($urandom); bit_val = 1'($urandom); bit_wr_en = 1;
                    step();
                    m_lat = dv;
                end
                3: set_pins(8'($urandom));
                default: step();
            endcase
            check_all("R2 random");
        end

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end
endmodule